// File: doc/BRIEF.md
# Transport Stream Packet Output Formatter

This block takes 188-byte transport packets from an upstream decoder, one byte per write, and presents them on a byte-wide output port. Each packet comes with one flag that marks it as uncorrectable. The formatter buffers the packets and drives them out with a generated output clock. Alongside the data it drives a packet-start strobe, a data-valid strobe and an active-low block-error strobe. It can also set the error-indicator bit in the header of a bad packet.

The output port runs at half the core clock rate. There is one output period for every two core cycles. A polarity control chooses which edge of the output clock launches the data. The port can send bytes in parallel or send one bit per period in serial mode. A swap control mirrors the bus, so in serial mode the data lane is either bit 0 or bit 7. An output-enable control, active low, holds back new packets and parks the output clock. A packet starts only after all of its bytes are in the buffer, so a packet is never sent with gaps.

Top module: `ts_pkt_formatter`

## Requirements
- R1: While reset is held and just after it is released, ts_valid and ts_sop are 0, ts_err_n is 1, ts_data is 0 and ts_clk is 0.
- R2: Between packets, ts_data is 0, ts_sop and ts_valid are 0, and ts_err_n is 1.
- R3: In parallel mode a packet occupies 188 consecutive output periods. ts_valid stays high through all of them, and ts_sop is high only in the first period. When a second complete packet is already buffered, it starts in the period that directly follows the last byte of the previous packet.
- R4: A packet that is not flagged leaves byte for byte in its input order and unchanged. Byte index 0 is the sync byte 0x47.
- R5: The uncorrectable flag is given with the first input byte of a packet. For such a packet ts_err_n is 0 in every period of the packet and in no period outside it. For a clean packet ts_err_n stays 1.
- R6: With cfg_tei_en=1, bit 7 of byte index 1 of an uncorrectable packet is output as 1. All other bits and bytes are unchanged.
- R7: With cfg_tei_en=0, byte index 1 is passed unchanged whether its bit 7 is 0 or 1, even when the packet is uncorrectable.
- R8: With cfg_clk_inv=1 the outputs change only when ts_clk falls and are stable at its rising edge. With cfg_clk_inv=0 these edges are reversed.
- R9: While cfg_oe_n=1 no new packet starts. While the port is idle under that condition ts_clk is held at 0. A buffered packet leaves once cfg_oe_n returns to 0.
- R10: In parallel mode with cfg_swap=1, byte bit k is driven on ts_data bit 7-k.
- R11: With cfg_serial=1 a packet takes 1504 periods, one bit per period, with the most significant bit of each byte first. The bit is on ts_data[0] when cfg_swap=0 and on ts_data[7] when cfg_swap=1, and all other bus bits are 0. ts_sop is high only in the first period.
- R12: A packet does not start before its 188th byte has been written, even when the input is slower than the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte write strobe |
| in_data | input | 8 | Input packet byte |
| in_bad | input | 1 | Uncorrectable flag, sampled with the first byte of a packet |
| cfg_tei_en | input | 1 | Set the header error bit of uncorrectable packets |
| cfg_clk_inv | input | 1 | 1: launch data on the falling edge of ts_clk; 0: launch on the rising edge |
| cfg_oe_n | input | 1 | Output enable, active low |
| cfg_swap | input | 1 | Mirror the output bus |
| cfg_serial | input | 1 | Serial mode, one bit per period |
| ts_clk | output | 1 | Output clock |
| ts_data | output | 8 | Output data bus |
| ts_sop | output | 1 | Packet-start strobe |
| ts_valid | output | 1 | Data-valid strobe |
| ts_err_n | output | 1 | Block-error strobe, active low |

## Verification
The bench drives clean packets and uncorrectable packets with header bytes whose error bit is first clear and then set, with header rewriting on and off. This separates a forced bit from a passed-through bit. The same packet is sent at both clock polarities, with the bus mirrored, and in serial mode on each lane. These runs separate launch-edge errors, bit-order errors and lane-selection errors. A slow input stream shows whether a packet can start early. Two buffered packets sent in succession show whether the second starts in the next period. A run with the output disabled shows whether a packet leaks out or the clock moves.

// File: rtl/ts_fmt_pkg.sv
package ts_fmt_pkg;

    typedef logic [7:0] byte_t;

    // Header position of the transport error indicator
    localparam int TEI_BYTE = 1;
    localparam int TEI_BIT  = 7;

    typedef struct packed {
        logic  clk;
        logic  sop;
        logic  valid;
        logic  err_n;
        byte_t data;
    } tsout_t;

    // Place a byte (parallel) or one bit of it (serial, MSB first) on the
    // bus, optionally mirrored end to end.
    function automatic byte_t lane_map(byte_t b, logic ser, logic [2:0] bsel,
                                       logic mirror);
        byte_t raw;
        byte_t r;
        raw = ser ? {7'b0, b[3'd7 - bsel]} : b;
        for (int i = 0; i < 8; i++) begin
            r[i] = mirror ? raw[7 - i] : raw[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/ts_pkt_fifo.sv
module ts_pkt_fifo
    import ts_fmt_pkg::*;
#(
    parameter int DEPTH     = 512,
    parameter int PKT_BYTES = 188
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  byte_t wr_data,
    input  logic  wr_bad,
    input  logic  pop,
    input  logic  start,
    output byte_t rd_data,
    output logic  rd_bad,
    output logic  pkt_ready
);
    localparam int AW = $clog2(DEPTH);
    localparam int BW = $clog2(PKT_BYTES);
    localparam int PW = $clog2(DEPTH / PKT_BYTES + 2);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [BW-1:0] wbyte;
        logic [PW-1:0] pkts;
    } fifo_st_t;

    fifo_st_t q, d;
    logic     pkt_done;
    logic [8:0] mem [DEPTH];

    always_comb begin
        d        = q;
        pkt_done = 1'b0;
        if (wr_en) begin
            d.wptr = q.wptr + AW'(1);
            if (q.wbyte == BW'(PKT_BYTES - 1)) begin
                d.wbyte  = '0;
                pkt_done = 1'b1;
            end else begin
                d.wbyte = q.wbyte + BW'(1);
            end
        end
        if (pop) begin
            d.rptr = q.rptr + AW'(1);
        end
        d.pkts = q.pkts + PW'(pkt_done) - PW'(start);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[q.wptr] <= {wr_bad, wr_data};
        end
    end

    assign {rd_bad, rd_data} = mem[q.rptr];
    assign pkt_ready         = (q.pkts != '0);

endmodule

// File: rtl/ts_out_seq.sv
module ts_out_seq
    import ts_fmt_pkg::*;
#(
    parameter int PKT_BYTES = 188
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pkt_ready,
    input  byte_t  rd_data,
    input  logic   rd_bad,
    output logic   pop,
    output logic   start,
    input  logic   tei_en,
    input  logic   clk_inv,
    input  logic   oe_n,
    input  logic   swap,
    input  logic   serial,
    output tsout_t out
);
    localparam int BW = $clog2(PKT_BYTES);
    localparam logic [BW-1:0] LAST_BYTE = BW'(PKT_BYTES - 1);
    localparam logic [BW-1:0] TEI_IDX   = BW'(TEI_BYTE);

    typedef struct packed {
        logic          ph;
        logic          active;
        logic          ser;
        logic          swp;
        logic          bad;
        logic [2:0]    ubit;
        logic [BW-1:0] ubyte;
        byte_t         sh;
        tsout_t        o;
    } seq_st_t;

    seq_st_t q, d;
    logic    byte_end;
    logic    pkt_end;
    logic    run;

    always_comb begin
        d        = q;
        d.ph     = ~q.ph;
        pop      = 1'b0;
        start    = 1'b0;
        byte_end = !q.ser || (q.ubit == 3'd7);
        pkt_end  = byte_end && (q.ubyte == LAST_BYTE);

        // A new output period begins whenever the phase wraps
        if (q.ph) begin
            if (q.active && !pkt_end) begin
                if (!byte_end) begin
                    d.ubit = q.ubit + 3'd1;
                end else begin
                    d.ubit  = 3'd0;
                    d.ubyte = q.ubyte + BW'(1);
                    pop     = 1'b1;
                    d.sh    = rd_data;
                    if ((d.ubyte == TEI_IDX) && q.bad && tei_en) begin
                        d.sh[TEI_BIT] = 1'b1;
                    end
                end
            end else if (pkt_ready && !oe_n) begin
                start    = 1'b1;
                pop      = 1'b1;
                d.active = 1'b1;
                d.ser    = serial;
                d.swp    = swap;
                d.bad    = rd_bad;
                d.ubyte  = '0;
                d.ubit   = 3'd0;
                d.sh     = rd_data;
            end else begin
                d.active = 1'b0;
            end
        end

        run        = d.active || !oe_n;
        d.o.valid  = d.active;
        d.o.sop    = d.active && (d.ubyte == '0) && (d.ubit == 3'd0);
        d.o.err_n  = !(d.active && d.bad);
        d.o.data   = d.active ? lane_map(d.sh, d.ser, d.ubit, d.swp) : '0;
        d.o.clk    = run ? (clk_inv ? d.ph : ~d.ph) : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.o.err_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign out = q.o;

endmodule

// File: rtl/ts_pkt_formatter.sv
module ts_pkt_formatter
    import ts_fmt_pkg::*;
#(
    parameter int DEPTH     = 512,
    parameter int PKT_BYTES = 188
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_bad,
    input  logic       cfg_tei_en,
    input  logic       cfg_clk_inv,
    input  logic       cfg_oe_n,
    input  logic       cfg_swap,
    input  logic       cfg_serial,
    output logic       ts_clk,
    output logic [7:0] ts_data,
    output logic       ts_sop,
    output logic       ts_valid,
    output logic       ts_err_n
);
    byte_t  rd_data;
    logic   rd_bad;
    logic   pkt_ready;
    logic   pop;
    logic   start;
    tsout_t out;

    ts_pkt_fifo #(.DEPTH(DEPTH), .PKT_BYTES(PKT_BYTES)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (in_valid),
        .wr_data   (in_data),
        .wr_bad    (in_bad),
        .pop       (pop),
        .start     (start),
        .rd_data   (rd_data),
        .rd_bad    (rd_bad),
        .pkt_ready (pkt_ready)
    );

    ts_out_seq #(.PKT_BYTES(PKT_BYTES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pkt_ready (pkt_ready),
        .rd_data   (rd_data),
        .rd_bad    (rd_bad),
        .pop       (pop),
        .start     (start),
        .tei_en    (cfg_tei_en),
        .clk_inv   (cfg_clk_inv),
        .oe_n      (cfg_oe_n),
        .swap      (cfg_swap),
        .serial    (cfg_serial),
        .out       (out)
    );

    assign ts_clk   = out.clk;
    assign ts_data  = out.data;
    assign ts_sop   = out.sop;
    assign ts_valid = out.valid;
    assign ts_err_n = out.err_n;

endmodule

// File: rtl/ts_pkt_formatter_chk.sv
module ts_pkt_formatter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_clk_inv,
    input logic       cfg_oe_n,
    input logic       ts_clk,
    input logic [7:0] ts_data,
    input logic       ts_sop,
    input logic       ts_valid,
    input logic       ts_err_n
);
    AST_SOP_IN_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
        ts_sop |-> ts_valid); // R3

    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !ts_valid |-> (ts_data == 8'd0 && ts_err_n)); // R2

    AST_ERR_ONLY_IN_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
        !ts_err_n |-> ts_valid); // R5

    AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_valid && $past(ts_valid) && !ts_sop) |-> $stable(ts_err_n)); // R5

    AST_STABLE_AT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ts_clk) && ts_clk == cfg_clk_inv)
            |-> ($stable(ts_data) && $stable(ts_valid) && $stable(ts_sop))); // R8

    AST_CLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ts_valid && $past(cfg_oe_n)) |-> !ts_clk); // R9

endmodule

bind ts_pkt_formatter ts_pkt_formatter_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_clk_inv (cfg_clk_inv),
    .cfg_oe_n    (cfg_oe_n),
    .ts_clk      (ts_clk),
    .ts_data     (ts_data),
    .ts_sop      (ts_sop),
    .ts_valid    (ts_valid),
    .ts_err_n    (ts_err_n)
);

// File: tb/ts_pkt_formatter_test.sv
`timescale 1ns/1ps
module ts_pkt_formatter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'd0;
    logic       in_bad = 1'b0;
    logic       cfg_tei_en = 1'b1;
    logic       cfg_clk_inv = 1'b1;
    logic       cfg_oe_n = 1'b0;
    logic       cfg_swap = 1'b0;
    logic       cfg_serial = 1'b0;
    logic       ts_clk;
    logic [7:0] ts_data;
    logic       ts_sop;
    logic       ts_valid;
    logic       ts_err_n;

    always #2 clk = ~clk;

    ts_pkt_formatter uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_bad(in_bad), .cfg_tei_en(cfg_tei_en), .cfg_clk_inv(cfg_clk_inv),
        .cfg_oe_n(cfg_oe_n), .cfg_swap(cfg_swap), .cfg_serial(cfg_serial),
        .ts_clk(ts_clk), .ts_data(ts_data), .ts_sop(ts_sop),
        .ts_valid(ts_valid), .ts_err_n(ts_err_n)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Monitor state
    logic [7:0] exp_b [2][188];
    logic [7:0] rx_b  [2][188];
    int   rx_len [2];
    int   rx_sopbad [2];
    int   rx_errbad [2];
    int   rx_first [2];
    int   rx_last [2];
    logic rx_isbad [2];
    int   rx_cnt = 0;
    int   tx_cnt = 0;
    int   slot = 0;
    int   u = 0;
    bit   in_pkt = 1'b0;
    int   unstable = 0;
    int   idle_bad = 0;
    int   lane_bad = 0;
    int   toggles = 0;
    int   cyc = 0;
    int   last_wr = 0;
    logic prev_clk = 1'b0;
    logic [7:0] prev_data = 8'd0;
    logic prev_valid = 1'b0;
    logic prev_sop = 1'b0;

    task automatic close_pkt();
        rx_len[slot] = u;
        in_pkt = 1'b0;
        rx_cnt++;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            in_pkt   = 1'b0;
            prev_clk = 1'b0;
        end else begin
            if (ts_clk !== prev_clk) toggles++;
            if (ts_clk !== prev_clk && ts_clk === cfg_clk_inv) begin
                if (ts_data !== prev_data || ts_valid !== prev_valid || ts_sop !== prev_sop)
                    unstable++;
                if (ts_valid && (ts_sop || !in_pkt)) begin
                    if (in_pkt) close_pkt();
                    slot = rx_cnt % 2;
                    in_pkt = 1'b1;
                    u = 0;
                    rx_isbad[slot]  = !ts_err_n;
                    rx_first[slot]  = cyc;
                    rx_sopbad[slot] = 0;
                    rx_errbad[slot] = 0;
                end
                if (ts_valid) begin
                    if (ts_sop != (u == 0)) rx_sopbad[slot]++;
                    if (ts_err_n == rx_isbad[slot]) rx_errbad[slot]++;
                    if (cfg_serial) begin
                        if ((cfg_swap ? ts_data[6:0] : ts_data[7:1]) != 7'd0) lane_bad++;
                        if (u / 8 < 188)
                            rx_b[slot][u/8] = {rx_b[slot][u/8][6:0],
                                               cfg_swap ? ts_data[7] : ts_data[0]};
                    end else if (u < 188) begin
                        rx_b[slot][u] = ts_data;
                    end
                    u++;
                    rx_last[slot] = cyc;
                end else begin
                    if (in_pkt) close_pkt();
                    if (ts_data != 8'd0 || ts_sop || !ts_err_n) idle_bad++;
                end
            end
            prev_clk   = ts_clk;
            prev_data  = ts_data;
            prev_valid = ts_valid;
            prev_sop   = ts_sop;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7 - i];
        return r;
    endfunction

    task automatic send_pkt(input logic [7:0] hdr1, input logic [7:0] seed,
                            input bit bad, input int gap);
        int s;
        logic [7:0] b;
        s = tx_cnt % 2;
        for (int i = 0; i < 188; i++) begin
            if (i == 0)      b = 8'h47;
            else if (i == 1) b = hdr1;
            else             b = seed + 8'(i * 3);
            exp_b[s][i] = (i == 1 && bad && cfg_tei_en) ? (b | 8'h80) : b;
            @(posedge clk); #1;
            in_valid = 1'b1;
            in_data  = b;
            in_bad   = bad;
            if (gap > 0) begin
                @(posedge clk); #1;
                in_valid = 1'b0;
                repeat (gap - 1) @(posedge clk);
            end
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
        last_wr  = cyc;
        tx_cnt++;
    endtask

    task automatic wait_rx(input int target);
        for (int n = 0; n < 20000 && rx_cnt < target; n++) @(posedge clk);
        repeat (4) @(posedge clk);
    endtask

    task automatic verify(input string req, input int s, input int len,
                          input bit bad, input bit mirror);
        int mism = 0;
        int first_a = 0;
        int first_e = 0;
        logic [7:0] e;
        chk(rx_len[s] == len, {req, " length"}, rx_len[s], len);
        chk(rx_sopbad[s] == 0, {req, " sop placement"}, rx_sopbad[s], 0);
        chk(rx_errbad[s] == 0, {req, " err_n held"}, rx_errbad[s], 0);
        chk(rx_isbad[s] == bad, {req, " err_n level"}, int'(rx_isbad[s]), int'(bad));
        for (int i = 0; i < 188; i++) begin
            e = mirror ? rev8(exp_b[s][i]) : exp_b[s][i];
            if (rx_b[s][i] !== e) begin
                if (mism == 0) begin first_a = rx_b[s][i]; first_e = e; end
                mism++;
            end
        end
        chk(mism == 0, {req, " content"}, first_a, first_e);
    endtask

    // R1: reset state
    task automatic t_reset();
        @(negedge clk);
        chk(!ts_valid && !ts_sop && ts_err_n && ts_data == 0 && !ts_clk,
            "R1 during reset", {ts_valid, ts_sop, ts_err_n, ts_clk}, 4'b0010);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!ts_valid && !ts_sop && ts_err_n && ts_data == 0,
            "R1 after release", {ts_valid, ts_sop, ts_err_n}, 3'b001);
    endtask

    task automatic t_par_good();
        send_pkt(8'h01, 8'h10, 1'b0, 0);
        wait_rx(rx_cnt + 1);
        verify("R3 R4 clean parallel", (rx_cnt - 1) % 2, 188, 1'b0, 1'b0);
    endtask

    task automatic t_tei_on();
        send_pkt(8'h12, 8'h20, 1'b1, 0);
        wait_rx(rx_cnt + 1);
        verify("R5 R6 bad with tei", (rx_cnt - 1) % 2, 188, 1'b1, 1'b0);
        chk(rx_b[(rx_cnt - 1) % 2][1] == 8'h92, "R6 header bit",
            rx_b[(rx_cnt - 1) % 2][1], 8'h92);
    endtask

    task automatic t_tei_off();
        cfg_tei_en = 1'b0;
        send_pkt(8'h12, 8'h30, 1'b1, 0);
        wait_rx(rx_cnt + 1);
        verify("R7 tei off clear bit", (rx_cnt - 1) % 2, 188, 1'b1, 1'b0);
        chk(rx_b[(rx_cnt - 1) % 2][1] == 8'h12, "R7 header kept 0x12",
            rx_b[(rx_cnt - 1) % 2][1], 8'h12);
        send_pkt(8'h9F, 8'h40, 1'b1, 0);
        wait_rx(rx_cnt + 1);
        chk(rx_b[(rx_cnt - 1) % 2][1] == 8'h9F, "R7 header kept 0x9F",
            rx_b[(rx_cnt - 1) % 2][1], 8'h9F);
        cfg_tei_en = 1'b1;
    endtask

    task automatic t_inv0();
        cfg_clk_inv = 1'b0;
        repeat (4) @(posedge clk);
        send_pkt(8'h05, 8'h50, 1'b0, 0);
        wait_rx(rx_cnt + 1);
        verify("R8 rising launch", (rx_cnt - 1) % 2, 188, 1'b0, 1'b0);
        chk(unstable == 0, "R8 stable at sample edge", unstable, 0);
        cfg_clk_inv = 1'b1;
        repeat (4) @(posedge clk);
    endtask

    task automatic t_swap_par();
        cfg_swap = 1'b1;
        send_pkt(8'h0C, 8'h61, 1'b0, 0);
        wait_rx(rx_cnt + 1);
        verify("R10 mirrored bus", (rx_cnt - 1) % 2, 188, 1'b0, 1'b1);
        cfg_swap = 1'b0;
    endtask

    task automatic t_serial(input bit sw);
        cfg_serial = 1'b1;
        cfg_swap   = sw;
        send_pkt(8'h3A, sw ? 8'h7E : 8'h11, 1'b1, 0);
        wait_rx(rx_cnt + 1);
        verify(sw ? "R11 serial bit7" : "R11 serial bit0", (rx_cnt - 1) % 2,
               1504, 1'b1, 1'b0);
        chk(lane_bad == 0, "R11 unused lanes zero", lane_bad, 0);
        cfg_serial = 1'b0;
        cfg_swap   = 1'b0;
    endtask

    task automatic t_oe();
        int c0, t0;
        cfg_oe_n = 1'b1;
        repeat (5) @(posedge clk);
        t0 = toggles;
        c0 = rx_cnt;
        send_pkt(8'h02, 8'h70, 1'b0, 0);
        repeat (400) @(posedge clk);
        chk(rx_cnt == c0, "R9 no packet while disabled", rx_cnt, c0);
        chk(toggles == t0, "R9 clock parked", toggles - t0, 0);
        cfg_oe_n = 1'b0;
        wait_rx(c0 + 1);
        verify("R9 released packet", c0 % 2, 188, 1'b0, 1'b0);
    endtask

    task automatic t_slow();
        send_pkt(8'h04, 8'h80, 1'b0, 3);
        wait_rx(rx_cnt + 1);
        chk(rx_first[(rx_cnt - 1) % 2] > last_wr - 2, "R12 start after last byte",
            rx_first[(rx_cnt - 1) % 2], last_wr);
        verify("R12 slow input", (rx_cnt - 1) % 2, 188, 1'b0, 1'b0);
    endtask

    task automatic t_b2b();
        int c0;
        c0 = rx_cnt;
        send_pkt(8'h06, 8'h90, 1'b0, 0);
        send_pkt(8'h07, 8'hA0, 1'b1, 0);
        wait_rx(c0 + 2);
        verify("R3 first of pair", c0 % 2, 188, 1'b0, 1'b0);
        verify("R3 R5 second of pair", (c0 + 1) % 2, 188, 1'b1, 1'b0);
        chk(rx_first[(c0 + 1) % 2] - rx_last[c0 % 2] == 2, "R3 back to back",
            rx_first[(c0 + 1) % 2] - rx_last[c0 % 2], 2);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        repeat (6) @(posedge clk);
        t_par_good();
        t_tei_on();
        t_tei_off();
        t_inv0();
        t_swap_par();
        t_serial(1'b0);
        t_serial(1'b1);
        t_oe();
        t_slow();
        t_b2b();
        chk(idle_bad == 0, "R2 idle levels", idle_bad, 0);
        chk(unstable == 0, "R8 no change at sample edge", unstable, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule